// File: doc/BRIEF.md
# Per-Block Write Protection Register Bank

This block holds one small protection register for each of eight memory blocks and decides, when the write engine wants to start a program or erase, whether the target block may be altered. Each register carries a write-lock flag and a lock-down flag. Two active-low hardware inputs add protection on top of the registers. One guards the top block. The other guards every other block.

Software reads and writes the registers through a simple indexed port. A read returns its data one clock after the request. The lock-down flag is sticky: once it is set, the register no longer accepts writes, and only a reset releases it. The hardware inputs take part in the permit decision but are never visible in the register readback. While the write engine reports busy, every register access is dropped. The permit answer is combinational, so the engine captures the protection state at the moment it starts an operation.

Top module: `blk_lock_bank`

## Requirements
- R1: Each register reads back as an 8-bit value with the write-lock flag in bit 0, the lock-down flag in bit 1 and zeros in bits 7..2. An accepted read of index 0..7 updates `reg_rdata` on the clock edge where `reg_rd` is sampled. A read in the same cycle as a write returns the value from before the write.
- R2: After reset, every register has write-lock = 1 and lock-down = 0, and `reg_rdata` is 0x00.
- R3: An accepted write to a register whose lock-down flag is 0 loads `reg_wdata[0]` into write-lock and `reg_wdata[1]` into lock-down.
- R4: While a register's lock-down flag is 1, writes to it change nothing, and that includes writes with bit 1 = 0. Only reset clears lock-down.
- R5: While `top_lock_n` is 0, start requests for block 7 are denied whatever its write-lock flag. While `wp_n` is 0, requests for blocks 0..6 are denied. The readback does not show either input.
- R6: The two protect inputs act independently. `top_lock_n` has no effect on blocks 0..6, and `wp_n` has no effect on block 7.
- R7: `op_permit` is combinational. It equals `op_start` AND NOT (write-lock of `op_blk` OR the protect input that applies to `op_blk`).
- R8: While `busy` is 1, reads and writes are ignored. `reg_rdata` holds its value and the registers do not change.
- R9: Indexes 8..15 are unused. Reading one returns 0x00 and writing one changes no register.
- R10: A block that is locked down with write-lock = 0 is denied while its protect input is low and permitted while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_idx | input | 4 | Register index (0..7 valid) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| busy | input | 1 | Write engine busy; register accesses ignored |
| op_start | input | 1 | Program/erase start request |
| op_blk | input | 3 | Target block of the request |
| op_permit | output | 1 | Request may proceed (same cycle) |
| top_lock_n | input | 1 | Active-low protect for the top block |
| wp_n | input | 1 | Active-low protect for blocks 0..6 |

## Verification
The bench looks for registers that unfreeze after lock-down. A design that got this wrong would let a write with bit 1 cleared drop the lock-down flag, or would still change write-lock on a frozen block. It also checks that the protect inputs stay out of the readback: a design that folded them in would show write-lock as 1 while a pin is low. It checks the pairing of each pin with its blocks, so a swapped or shared pin shows up as a wrong permit on block 7 or on blocks 0..6. Finally it drives accesses during busy and to the unused indexes, which catches a design that updates state or read data when it should have held.

// File: rtl/blk_lock_bank.sv
module blk_lock_bank #(
  parameter int NBLK  = 8,
  parameter int IDX_W = 4,
  parameter int DW    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_rd,
  input  logic                    reg_wr,
  input  logic [IDX_W-1:0]        reg_idx,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  input  logic                    busy,
  input  logic                    op_start,
  input  logic [$clog2(NBLK)-1:0] op_blk,
  output logic                    op_permit,
  input  logic                    top_lock_n,
  input  logic                    wp_n
);
  localparam int BW  = $clog2(NBLK);
  localparam int TOP = NBLK - 1;

  logic [NBLK-1:0] wlock, ldown;

  wire [BW-1:0] sel      = reg_idx[BW-1:0];
  wire          idx_ok   = reg_idx < IDX_W'(NBLK);
  wire          acc_rd   = reg_rd && !busy;
  wire          acc_wr   = reg_wr && !busy && idx_ok && !ldown[sel];
  wire          is_top   = op_blk == BW'(TOP);
  wire          pin_prot = is_top ? !top_lock_n : !wp_n;
  wire          unused_wdata = ^reg_wdata[DW-1:2];

  assign op_permit = op_start && !(wlock[op_blk] || pin_prot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlock     <= '1;
      ldown     <= '0;
      reg_rdata <= '0;
    end else begin
      if (acc_rd)
        reg_rdata <= idx_ok ? {{(DW-2){1'b0}}, ldown[sel], wlock[sel]} : '0;
      if (acc_wr) begin
        wlock[sel] <= reg_wdata[0];
        ldown[sel] <= reg_wdata[1];
      end
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_chk
    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ldown[i] |=> ldown[i] && $stable(wlock[i]));
  end

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reg_rdata) && $stable(wlock) && $stable(ldown));

  assert_unused_idx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !idx_ok) |=> $stable(wlock) && $stable(ldown));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:2] == '0);

  assert_top_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && is_top && !top_lock_n) |-> !op_permit);

  assert_wp_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !is_top && !wp_n) |-> !op_permit);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start |-> !op_permit);
endmodule

// File: tb/tb_blk_lock_bank.sv
`timescale 1ns/1ps
module tb_blk_lock_bank;
  logic clk = 0, rst_n = 0;
  logic reg_rd = 0, reg_wr = 0, busy = 0, op_start = 0;
  logic top_lock_n = 1, wp_n = 1;
  logic [3:0] reg_idx = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [2:0] op_blk = 0;
  logic op_permit;

  blk_lock_bank dut (.clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .op_start(op_start), .op_blk(op_blk), .op_permit(op_permit),
    .top_lock_n(top_lock_n), .wp_n(wp_n));

  always #2 clk = ~clk;

  int vecs = 0, fails = 0;
  int wl[8], ld[8];
  int rd_exp = 0;

  task automatic check(string tag, string what, int got, int exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin wl[i] = 1; ld[i] = 0; end
    rd_exp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_rd = 0; reg_wr = 0; op_start = 0; busy = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check("R2", "rdata after reset", reg_rdata, 0);
  endtask

  task automatic step(bit rd, bit wr, int idx, int wd, bit st, int blk,
                      bit bz, bit tl, bit wp, string tag);
    int prot, exp_p;
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_idx = 4'(idx); reg_wdata = 8'(wd);
    op_start = st; op_blk = 3'(blk); busy = bz; top_lock_n = tl; wp_n = wp;
    #1;
    prot = (blk == 7) ? !tl : !wp;
    exp_p = st && !(wl[blk] || prot);
    check(tag, "op_permit", op_permit, exp_p);
    @(posedge clk);
    #1;
    if (rd && !bz) rd_exp = (idx < 8) ? (ld[idx] << 1 | wl[idx]) : 0;
    if (wr && !bz && idx < 8 && !ld[idx]) begin
      wl[idx] = wd & 1; ld[idx] = (wd >> 1) & 1;
    end
    check(tag, "reg_rdata", reg_rdata, rd_exp);
  endtask

  task automatic rd(int idx, string tag);
    step(1, 0, idx, 0, 0, 0, 0, 1, 1, tag);
  endtask
  task automatic wr(int idx, int wd, string tag);
    step(0, 1, idx, wd, 0, 0, 0, 1, 1, tag);
  endtask
  task automatic op(int blk, bit tl, bit wp, string tag);
    step(0, 0, 0, 0, 1, blk, 0, tl, wp, tag);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R2 / R1: reset value reads as write-locked
    for (int i = 0; i < 8; i++) rd(i, "R2");
    for (int i = 0; i < 8; i++) op(i, 1, 1, "R2");
    // R3: unlock blocks 0,3,7
    wr(0, 8'h00, "R3"); wr(3, 8'hFC, "R3"); wr(7, 8'h00, "R3");
    rd(3, "R1"); op(3, 1, 1, "R3"); op(0, 1, 1, "R7");
    // R1: read and write together returns old value
    step(1, 1, 5, 8'h00, 0, 0, 0, 1, 1, "R1");
    rd(5, "R1");
    // R5 / R6: pins override, independent, not in readback
    op(7, 0, 1, "R5"); op(0, 0, 1, "R6"); op(0, 1, 0, "R5"); op(7, 1, 0, "R6");
    step(1, 0, 7, 0, 1, 7, 0, 0, 1, "R5");
    // R10: locked-down with write-lock 0
    wr(7, 8'h02, "R10");
    op(7, 0, 1, "R10"); op(7, 1, 1, "R10");
    // R4: frozen register
    wr(7, 8'h01, "R4"); wr(7, 8'h00, "R4"); rd(7, "R4"); op(7, 1, 1, "R4");
    wr(2, 8'h03, "R4"); wr(2, 8'h00, "R4"); rd(2, "R4");
    // R8: busy ignores access
    step(0, 1, 4, 8'h00, 0, 0, 1, 1, 1, "R8");
    step(1, 0, 0, 0, 0, 0, 1, 1, 1, "R8");
    rd(4, "R8");
    // R9: unused indexes
    wr(9, 8'h00, "R9"); rd(9, "R9"); rd(15, "R9"); rd(1, "R9");
    // R4: reset releases lock-down
    do_reset();
    rd(7, "R4"); wr(7, 8'h00, "R4"); rd(7, "R4");
    // R7: random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom;
      step(r[0], r[1], int'(r[7:4]), int'(r[15:8]), r[16], int'(r[19:17]),
           r[21:20] == 0, r[23:22] != 0, r[25:24] != 0, "R7");
      if (n % 700 == 699) do_reset();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule